// File: doc/BRIEF.md
# Bit-Steered Cross-Correlation Accumulator

This block maintains a running cross-correlation matrix between a vector of antipodal bits (ROWS entries, each +1 or -1) and a vector of COLS signed 8-bit received samples. Each matrix entry (row i, column j) accumulates bit i times sample j. A multiply by an antipodal bit is only a sign choice, so bit i decides whether sample j is added to or subtracted from the stored entry. No multiplier is used. The matrix sits in an on-chip RAM, and a sequencer walks every entry with one shared saturating adder.

A sweep starts on a one-cycle `start` pulse. At that edge the block captures the bit vector, the operation, the bank and one of two sample vectors, either pilot or data, as chosen by `src_sel`. An accumulate sweep adds a new bit/sample pair into the window. A retire sweep removes the oldest pair by inverting the add/subtract sense. Complex samples use two banks, one for real parts and one for imaginary parts, and each bank gets its own pass. The consumer reads the matrix through a separate registered read port.

Top module: `bitsteer_xcorr`

## Requirements
- R1: After reset is released the block zeroes all 2·ROWS·COLS entries. `busy` stays high for exactly 2·ROWS·COLS cycles while it does so, and every entry then reads 0.
- R2: In an accumulate sweep (`op_retire`=0), a bit value of 1 means +1 and adds the sample to the entry. A bit value of 0 means -1 and subtracts the sample. Bit i steers row i, and sample j sits at `vec[j*8 +: 8]`.
- R3: In a retire sweep (`op_retire`=1), the sense is inverted: bit 1 subtracts the sample and bit 0 adds it.
- R4: Each updated entry saturates to the signed range -128..127 instead of wrapping.
- R5: `src_sel`=0 selects `pilot_vec` as the sample vector and `src_sel`=1 selects `data_vec`.
- R6: `imag_sel` picks the bank, where 0 means addresses 0..ROWS·COLS-1 and 1 means the upper half. A sweep leaves the other bank unchanged.
- R7: A sweep costs three cycles per entry (read, add, write), with column fastest and then row. `busy` is high for exactly 3·ROWS·COLS cycles. `done` pulses for one cycle in the cycle `busy` falls.
- R8: A `start` pulse while `busy` is high is ignored.
- R9: Changes on the sample, bit, bank, source and operation inputs during a sweep have no effect on that sweep.
- R10: `rd_data` returns the entry at `rd_addr` = bank·ROWS·COLS + row·COLS + col one cycle after the address is applied.
- R11: While `rst` is high, `busy` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sweep when idle |
| op_retire | input | 1 | 0 = accumulate pair, 1 = retire oldest pair |
| imag_sel | input | 1 | Bank select: 0 real, 1 imaginary |
| src_sel | input | 1 | Sample source: 0 pilot, 1 data |
| bits_in | input | ROWS | Antipodal bits, 1 = +1, 0 = -1 |
| pilot_vec | input | COLS·SW | Pilot sample vector |
| data_vec | input | COLS·SW | Data sample vector |
| rd_addr | input | AW | Consumer read address |
| rd_data | output | SW | Registered read data |
| busy | output | 1 | Sweep or clearing pass in progress |
| done | output | 1 | One-cycle pulse at sweep end |

## Verification
A wrong sense bit or operation latch flips the sign of whole rows of the matrix. It shows up in the readout that follows the very next sweep. A fault in the address counter or the state sequence changes the number of `busy` cycles, or it puts updates into the wrong bank or the wrong column. The `busy` count exposes this within one sweep of 3·ROWS·COLS cycles. Missing saturation shows as a sign wrap on the first entry that crosses the range. A late capture shows when inputs are disturbed in the middle of a sweep.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_FETCH,
    ST_MERGE,
    ST_STORE
  } seq_state_e;

endpackage

// File: rtl/xcorr_ram.sv
module xcorr_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  // port A: sequencer read-modify-write
  always_ff @(posedge clk) begin
    if (we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // port B: consumer read
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/xcorr_satacc.sv
module xcorr_satacc #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] smp,
  input  logic         negate,
  output logic [W-1:0] result
);

  localparam logic signed [W:0] HI = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] LO = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0] acc_x, smp_x, sum;

  always_comb begin
    acc_x = $signed({acc[W-1], acc});
    smp_x = $signed({smp[W-1], smp});
    if (negate) sum = acc_x - smp_x;
    else        sum = acc_x + smp_x;
    if (sum > HI)      result = HI[W-1:0];
    else if (sum < LO) result = LO[W-1:0];
    else               result = sum[W-1:0];
  end

endmodule

// File: rtl/xcorr_seq.sv
module xcorr_seq
  import xcorr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int SW   = 8,
  parameter int AW   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 op_retire,
  input  logic                 imag_sel,
  input  logic                 src_sel,
  input  logic [ROWS-1:0]      bits_in,
  input  logic [COLS*SW-1:0]   pilot_vec,
  input  logic [COLS*SW-1:0]   data_vec,
  output logic                 ram_we,
  output logic [AW-1:0]        ram_addr,
  output logic [SW-1:0]        ram_wdata,
  input  logic [SW-1:0]        ram_rdata,
  output logic                 busy,
  output logic                 done
);

  localparam int ENT   = ROWS * COLS;
  localparam int DEPTH = 2 * ENT;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BANK_BASE = AW'(ENT);

  seq_state_e          state_q;
  logic [AW-1:0]       clr_q;
  logic [RW-1:0]       row_q;
  logic [CW-1:0]       col_q;
  logic                busy_q, done_q;
  logic [SW-1:0]       acc_q;
  logic [ROWS-1:0]     cap_bits;
  logic [COLS*SW-1:0]  cap_vec;
  logic                cap_retire, cap_bank;

  logic [COLS*SW-1:0]  src_vec;
  logic [AW-1:0]       cur_addr;
  logic [SW-1:0]       sample;
  logic                negate;
  logic [SW-1:0]       acc_next;

  // source multiplexer: pilot or data vector
  assign src_vec = src_sel ? data_vec : pilot_vec;

  assign cur_addr = (cap_bank ? BANK_BASE : '0)
                  + AW'(row_q) * AW'(COLS)
                  + AW'(col_q);

  assign sample = cap_vec[col_q*SW +: SW];
  // bit 1 = +1 adds on accumulate; retire flips the sense
  assign negate = ~(cap_bits[row_q] ^ cap_retire);

  xcorr_satacc #(.W(SW)) u_satacc (
    .acc    (ram_rdata),
    .smp    (sample),
    .negate (negate),
    .result (acc_next)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = cur_addr;
    ram_wdata = acc_q;
    if (state_q == ST_CLEAR) begin
      ram_we    = 1'b1;
      ram_addr  = clr_q;
      ram_wdata = '0;
    end else if (state_q == ST_STORE) begin
      ram_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CLEAR;
      clr_q      <= '0;
      row_q      <= '0;
      col_q      <= '0;
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      acc_q      <= '0;
      cap_bits   <= '0;
      cap_vec    <= '0;
      cap_retire <= 1'b0;
      cap_bank   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_CLEAR: begin
          if (clr_q == ADDR_LAST) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end else begin
            clr_q <= clr_q + AW'(1);
          end
        end
        ST_IDLE: begin
          if (start) begin
            cap_bits   <= bits_in;
            cap_vec    <= src_vec;
            cap_retire <= op_retire;
            cap_bank   <= imag_sel;
            row_q      <= '0;
            col_q      <= '0;
            state_q    <= ST_FETCH;
            busy_q     <= 1'b1;
          end
        end
        ST_FETCH: state_q <= ST_MERGE;
        ST_MERGE: begin
          acc_q   <= acc_next;
          state_q <= ST_STORE;
        end
        ST_STORE: begin
          if (col_q == COL_LAST) begin
            col_q <= '0;
            if (row_q == ROW_LAST) begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              row_q   <= row_q + RW'(1);
              state_q <= ST_FETCH;
            end
          end else begin
            col_q   <= col_q + CW'(1);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R1
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy_q);

  // R4
  sat_up_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MERGE && !negate && !sample[SW-1])
      |-> ($signed(acc_next) >= $signed(ram_rdata)));

  // R4
  sat_down_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MERGE && negate && !sample[SW-1])
      |-> ($signed(acc_next) <= $signed(ram_rdata)));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STORE) |-> ((ram_addr >= BANK_BASE) == cap_bank));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(cap_bits) && $stable(cap_vec)
                           && $stable(cap_retire) && $stable(cap_bank)));

  // R7
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/bitsteer_xcorr.sv
module bitsteer_xcorr #(
  parameter  int ROWS = 8,
  parameter  int COLS = 8,
  parameter  int SW   = 8,
  localparam int AW   = $clog2(2 * ROWS * COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_retire,
  input  logic               imag_sel,
  input  logic               src_sel,
  input  logic [ROWS-1:0]    bits_in,
  input  logic [COLS*SW-1:0] pilot_vec,
  input  logic [COLS*SW-1:0] data_vec,
  input  logic [AW-1:0]      rd_addr,
  output logic [SW-1:0]      rd_data,
  output logic               busy,
  output logic               done
);

  localparam int DEPTH = 2 * ROWS * COLS;

  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [SW-1:0] ram_wdata, ram_rdata;

  xcorr_seq #(
    .ROWS(ROWS), .COLS(COLS), .SW(SW), .AW(AW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_retire (op_retire),
    .imag_sel  (imag_sel),
    .src_sel   (src_sel),
    .bits_in   (bits_in),
    .pilot_vec (pilot_vec),
    .data_vec  (data_vec),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .done      (done)
  );

  xcorr_ram #(
    .DW(SW), .DEPTH(DEPTH), .AW(AW)
  ) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .a_addr  (ram_addr),
    .a_wdata (ram_wdata),
    .a_rdata (ram_rdata),
    .b_addr  (rd_addr),
    .b_rdata (rd_data)
  );

endmodule

// File: tb/bitsteer_xcorr_tb_top.sv
`timescale 1ns/1ps
module bitsteer_xcorr_tb_top;

  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int SW    = 8;
  localparam int ENT   = ROWS * COLS;
  localparam int DEPTH = 2 * ENT;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst = 1'b1;
  logic               start = 1'b0, op_retire = 1'b0, imag_sel = 1'b0, src_sel = 1'b0;
  logic [ROWS-1:0]    bits_in = '0;
  logic [COLS*SW-1:0] pilot_vec = '0, data_vec = '0;
  logic [AW-1:0]      rd_addr = '0;
  logic [SW-1:0]      rd_data;
  logic               busy, done;

  bitsteer_xcorr #(.ROWS(ROWS), .COLS(COLS), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_retire(op_retire),
    .imag_sel(imag_sel), .src_sel(src_sel), .bits_in(bits_in),
    .pilot_vec(pilot_vec), .data_vec(data_vec), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  int    model [DEPTH];
  int    exp_q [$];
  int    addr_q[$];
  string tag_q [$];
  logic  rd_req = 1'b0, pend_q = 1'b0;
  int    checks = 0, fails = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) pend_q <= rd_req;
  always @(negedge clk) begin
    int e, a, got;
    string t;
    if (pend_q) begin
      e = exp_q.pop_front();
      a = addr_q.pop_front();
      t = tag_q.pop_front();
      got = int'($signed(rd_data));
      chk(got == e, $sformatf("%s addr=%0d", t, a), got, e);
    end
  end

  task automatic readout(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      rd_req  = 1'b1;
      exp_q.push_back(model[a]);
      addr_q.push_back(a);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [COLS*SW-1:0] mkvec(int base, int step);
    logic [COLS*SW-1:0] v;
    for (int j = 0; j < COLS; j++) v[j*SW +: SW] = SW'(base + step * j);
    return v;
  endfunction

  task automatic sweep(bit ret, bit bank, bit src, logic [ROWS-1:0] b,
                       logic [COLS*SW-1:0] pv, logic [COLS*SW-1:0] dv,
                       bit disturb);
    int cnt;
    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < COLS; j++) begin
        int s, v, idx;
        s   = src ? int'($signed(dv[j*SW +: SW])) : int'($signed(pv[j*SW +: SW]));
        idx = bank * ENT + i * COLS + j;
        v   = (b[i] ^ ret) ? model[idx] + s : model[idx] - s;
        if (v > 127)  v = 127;
        if (v < -128) v = -128;
        model[idx] = v;
      end
    end
    @(negedge clk);
    op_retire = ret; imag_sel = bank; src_sel = src;
    bits_in = b; pilot_vec = pv; data_vec = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 10000) begin
      cnt++;
      if (disturb && cnt == 5) begin
        start = 1'b1; bits_in = ~b; pilot_vec = ~pv; data_vec = ~dv;
        op_retire = ~ret; imag_sel = ~bank; src_sel = ~src;
      end
      if (disturb && cnt == 6) start = 1'b0;
      @(negedge clk);
    end
    chk(cnt == 3 * ENT, "R7 busy length of sweep", cnt, 3 * ENT);
    chk(done == 1'b1, "R7 done with busy fall", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle only", int'(done), 0);
  endtask

  initial begin
    int cnt;
    for (int a = 0; a < DEPTH; a++) model[a] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11 busy during reset", int'(busy), 1);
    chk(done == 1'b0, "R11 done during reset", int'(done), 0);
    rst = 1'b0;
    cnt = 0;
    while (busy && cnt < 10000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == DEPTH, "R1 clearing pass length", cnt, DEPTH);
    readout("R1 R10 cleared matrix");

    sweep(1'b0, 1'b0, 1'b0, 8'hA5, mkvec(-7, 3), mkvec(50, -9), 1'b0);
    readout("R2 R5 R6 accumulate pilot bank0");

    sweep(1'b0, 1'b1, 1'b1, 8'h3C, mkvec(1, 1), mkvec(-60, 17), 1'b0);
    readout("R5 R6 accumulate data bank1");

    sweep(1'b1, 1'b0, 1'b0, 8'hA5, mkvec(-7, 3), mkvec(9, 9), 1'b0);
    readout("R3 retire pilot bank0");

    sweep(1'b1, 1'b1, 1'b0, 8'h0F, mkvec(20, -5), mkvec(0, 0), 1'b0);
    readout("R3 retire with mixed bits bank1");

    sweep(1'b0, 1'b0, 1'b1, 8'h0F, mkvec(0, 0), {4{8'h80, 8'h7F}}, 1'b0);
    sweep(1'b0, 1'b0, 1'b1, 8'h0F, mkvec(0, 0), {4{8'h80, 8'h7F}}, 1'b0);
    readout("R4 saturation after two full-scale adds");
    sweep(1'b1, 1'b0, 1'b0, 8'h33, {4{8'h81, 8'h7E}}, mkvec(0, 0), 1'b0);
    readout("R4 saturation on retire from rails");

    sweep(1'b0, 1'b1, 1'b0, 8'h96, mkvec(-30, 11), mkvec(4, 4), 1'b1);
    readout("R8 R9 start and inputs disturbed mid-sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule